// File: doc/BRIEF.md
# Strap-Configured Expansion ROM Reader

This block reads bytes from a slow external ROM over one shared 8-bit bidirectional bus. A host raises a one-cycle request with a byte address of up to 20 bits. The block sends that address out over the bus one byte at a time. Each byte has its own latch strobe, so an external 8-bit holding register captures each piece. The block then releases the bus and enables the ROM. It waits a fixed number of cycles and captures the byte the ROM returns. It reports that byte with a one-cycle done pulse.

The block does not need any configuration writes. A short, fixed time after reset is released, it reads the pull-up pattern on the idle bus. Three strap bits give the ROM size, from 16 KB to 1 MB in power-of-two steps, or say that no ROM is fitted. A fourth strap bit selects the fast or the slow wait count. The decoded size sets three things: the base-address mask that the block exposes, the masking of request addresses, and whether a third address latch is driven.

Top module: `exp_rom_bridge`

## Requirements
- R1: The bus is sampled on the 4th rising clock edge after reset is released. Bits [2:0] form the size code (0..6 means 16 KB shifted left by the code; 7 means no ROM). Bit 3 set selects slow access. No request is accepted before this edge.
- R2: `base_mask` has every bit at or above log2(ROM size) set and every lower bit clear. It is all zeros when no ROM is present.
- R3: Address bytes are driven with `bus_oe` high, least significant byte first. Each byte takes three cycles: setup, strobe, hold. Its strobe is high only in the middle cycle, and `bus_out` is unchanged across all three cycles. At most one strobe is high at any time.
- R4: Sizes up to 64 KB use exactly two address bytes and strobes 0 and 1. Larger sizes add a third byte on strobe 2.
- R5: Request address bits at or above log2(ROM size) are driven as zero.
- R6: After the last address byte, `bus_oe` is low while `ce_n` and `oe_n` are both low for 3 cycles (fast) or 7 cycles (slow). `bus_oe` is never high while `ce_n` or `oe_n` is low.
- R7: The bus byte is captured on the last enable cycle. `done` pulses for exactly the next cycle, with `rdata` showing the captured byte. `rdata` keeps that value until the next completion.
- R8: With no ROM present, an accepted request gives `done` in the next cycle with `rdata` = 0xFF. No strobe, `ce_n` or `oe_n` activity occurs.
- R9: A request raised while a read is in progress, or before configuration, is dropped. It produces no later strobe, enable or done.
- R10: During reset, `bus_oe`, the strobes, `done`, `rdata` and `base_mask` are zero, and `ce_n` and `oe_n` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | One-cycle read request |
| addr | input | 20 | Byte address of the request |
| rdata | output | 8 | Last byte read |
| done | output | 1 | One-cycle completion pulse |
| bus_in | input | 8 | Shared bus input (straps and ROM data) |
| bus_out | output | 8 | Shared bus output value (address bytes) |
| bus_oe | output | 1 | Shared bus output enable |
| latch_stb | output | 3 | Address latch strobes, index 0 for the low byte |
| ce_n | output | 1 | ROM chip enable, active low |
| oe_n | output | 1 | ROM output enable, active low |
| base_mask | output | 32 | Decoded base-address mask |

## Verification
Two functions can fall in the same cycle. The first is the acceptance of a new request, which is judged only while the block is idle. The second is the progress of a read already under way, or of the strap window. The bench provokes this clash in two ways. It raises a request with a different address during the strap window, and again in the middle of the address phase of every configuration's first read. In each case it expects the original cycle to run unchanged, cycle by cycle, and it expects no second done. It also expects the returned byte to match the ROM model for the first address only. The sweep covers all eight size codes with both speeds.

// File: rtl/rom_bridge_pkg.sv
package rom_bridge_pkg;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_ADDR,
      ST_DATA,
      ST_DONE
   } rom_st_e;

   localparam logic [2:0] SIZE_NONE = 3'd7;

   typedef enum logic [1:0] {
      PH_SETUP,
      PH_STROBE,
      PH_HOLD
   } addr_ph_e;

endpackage

// File: rtl/rom_strap_decode.sv
module rom_strap_decode #(
   parameter int BUS_W       = 8,
   parameter int ADDR_W      = 20,
   parameter int MASK_W      = 32,
   parameter int MIN_LOG2    = 14,
   parameter int STRAP_DELAY = 4,
   parameter int NB_W        = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BUS_W-1:0]  bus_in,
   output logic              cfg_done,
   output logic              present,
   output logic              slow,
   output logic [NB_W-1:0]   nbytes,
   output logic [ADDR_W-1:0] addr_mask,
   output logic [MASK_W-1:0] base_mask
);
   import rom_bridge_pkg::*;

   localparam int CNT_W = $clog2(STRAP_DELAY + 1);
   localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(STRAP_DELAY - 1);

   logic [CNT_W-1:0] cnt_q;
   logic [2:0]       code_q;
   logic             slow_q;
   logic             done_q;
   logic [31:0]      log2_v;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         code_q <= SIZE_NONE;
         slow_q <= 1'b1;
         done_q <= 1'b0;
      end else if (!done_q) begin
         if (cnt_q == LAST_CNT) begin
            code_q <= bus_in[2:0];
            slow_q <= bus_in[3];
            done_q <= 1'b1;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign cfg_done = done_q;
   assign slow     = slow_q;
   assign present  = (code_q != SIZE_NONE);
   assign log2_v   = 32'(MIN_LOG2) + 32'(code_q);
   assign nbytes   = NB_W'((log2_v + 32'(BUS_W) - 1) / 32'(BUS_W));

   for (genvar i = 0; i < ADDR_W; i++) begin : g_amask
      assign addr_mask[i] = present && (32'(i) < log2_v);
   end

   for (genvar i = 0; i < MASK_W; i++) begin : g_bmask
      assign base_mask[i] = present && (32'(i) >= log2_v);
   end

endmodule

// File: rtl/rom_addr_mux.sv
module rom_addr_mux #(
   parameter int ADDR_W = 20,
   parameter int BUS_W  = 8,
   parameter int NLATCH = 3,
   parameter int IDX_W  = 2
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [IDX_W-1:0]  sel,
   output logic [BUS_W-1:0]  byte_o
);
   localparam int PAD_W = NLATCH * BUS_W;

   logic [PAD_W-1:0] padded;
   logic [BUS_W-1:0] slices [NLATCH];

   assign padded = PAD_W'(addr);

   for (genvar i = 0; i < NLATCH; i++) begin : g_slice
      assign slices[i] = padded[i*BUS_W +: BUS_W];
   end

   always_comb begin
      byte_o = '0;
      for (int i = 0; i < NLATCH; i++) begin
         if (sel == IDX_W'(i)) byte_o = slices[i];
      end
   end

endmodule

// File: rtl/rom_cycle_fsm.sv
module rom_cycle_fsm #(
   parameter int ADDR_W    = 20,
   parameter int BUS_W     = 8,
   parameter int NLATCH    = 3,
   parameter int IDX_W     = 2,
   parameter int NB_W      = 2,
   parameter int FAST_WAIT = 3,
   parameter int SLOW_WAIT = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_done,
   input  logic              present,
   input  logic              slow,
   input  logic [NB_W-1:0]   nbytes,
   input  logic              req,
   input  logic [ADDR_W-1:0] addr_m,
   input  logic [BUS_W-1:0]  bus_in,
   output logic [ADDR_W-1:0] addr_q,
   output logic [IDX_W-1:0]  byte_idx,
   output logic              drive,
   output logic [NLATCH-1:0] stb,
   output logic              ce_n,
   output logic              oe_n,
   output logic              done,
   output logic [BUS_W-1:0]  rdata
);
   import rom_bridge_pkg::*;

   localparam int WC_W = $clog2(SLOW_WAIT + 1);

   rom_st_e          st_q;
   addr_ph_e         ph_q;
   logic [IDX_W-1:0] idx_q;
   logic [WC_W-1:0]  wcnt_q;
   logic [WC_W-1:0]  wlim;
   logic [BUS_W-1:0] rdata_q;
   logic             last_byte;

   assign wlim      = slow ? WC_W'(SLOW_WAIT - 1) : WC_W'(FAST_WAIT - 1);
   assign last_byte = (32'(idx_q) + 1 == 32'(nbytes));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         ph_q    <= PH_SETUP;
         idx_q   <= '0;
         wcnt_q  <= '0;
         addr_q  <= '0;
         rdata_q <= '0;
      end else begin
         unique case (st_q)
            ST_IDLE: begin
               if (req && cfg_done) begin
                  if (present) begin
                     st_q   <= ST_ADDR;
                     ph_q   <= PH_SETUP;
                     idx_q  <= '0;
                     addr_q <= addr_m;
                  end else begin
                     st_q    <= ST_DONE;
                     rdata_q <= '1;
                  end
               end
            end
            ST_ADDR: begin
               unique case (ph_q)
                  PH_SETUP:  ph_q <= PH_STROBE;
                  PH_STROBE: ph_q <= PH_HOLD;
                  default: begin
                     ph_q <= PH_SETUP;
                     if (last_byte) begin
                        st_q   <= ST_DATA;
                        wcnt_q <= '0;
                     end else begin
                        idx_q <= idx_q + 1'b1;
                     end
                  end
               endcase
            end
            ST_DATA: begin
               if (wcnt_q == wlim) begin
                  rdata_q <= bus_in;
                  st_q    <= ST_DONE;
               end else begin
                  wcnt_q <= wcnt_q + 1'b1;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   for (genvar i = 0; i < NLATCH; i++) begin : g_stb
      assign stb[i] = (st_q == ST_ADDR) && (ph_q == PH_STROBE) && (idx_q == IDX_W'(i));
   end

   assign byte_idx = idx_q;
   assign drive    = (st_q == ST_ADDR);
   assign ce_n     = (st_q != ST_DATA);
   assign oe_n     = (st_q != ST_DATA);
   assign done     = (st_q == ST_DONE);
   assign rdata    = rdata_q;

endmodule

// File: rtl/exp_rom_bridge.sv
module exp_rom_bridge #(
   parameter int ADDR_W      = 20,
   parameter int BUS_W       = 8,
   parameter int MASK_W      = 32,
   parameter int MIN_LOG2    = 14,
   parameter int STRAP_DELAY = 4,
   parameter int FAST_WAIT   = 3,
   parameter int SLOW_WAIT   = 7,
   parameter int NLATCH      = (ADDR_W + BUS_W - 1) / BUS_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic [ADDR_W-1:0] addr,
   output logic [BUS_W-1:0]  rdata,
   output logic              done,
   input  logic [BUS_W-1:0]  bus_in,
   output logic [BUS_W-1:0]  bus_out,
   output logic              bus_oe,
   output logic [NLATCH-1:0] latch_stb,
   output logic              ce_n,
   output logic              oe_n,
   output logic [MASK_W-1:0] base_mask
);
   localparam int IDX_W = (NLATCH > 1) ? $clog2(NLATCH) : 1;
   localparam int NB_W  = $clog2(NLATCH + 1);

   if (MIN_LOG2 + 6 > ADDR_W) begin : g_chk_addr
      $error("ADDR_W too small for the largest strap size");
   end
   if (ADDR_W > MASK_W) begin : g_chk_mask
      $error("MASK_W must cover ADDR_W");
   end
   if (BUS_W < 4) begin : g_chk_bus
      $error("BUS_W must hold the four strap bits");
   end
   if (FAST_WAIT < 1 || SLOW_WAIT < FAST_WAIT) begin : g_chk_wait
      $error("wait counts must satisfy 1 <= FAST_WAIT <= SLOW_WAIT");
   end
   if (STRAP_DELAY < 1) begin : g_chk_dly
      $error("STRAP_DELAY must be at least one cycle");
   end
   if (NLATCH * BUS_W < ADDR_W) begin : g_chk_lat
      $error("NLATCH latches cannot hold ADDR_W bits");
   end

   logic              cfg_done;
   logic              present;
   logic              slow;
   logic [NB_W-1:0]   nbytes;
   logic [ADDR_W-1:0] addr_mask;
   logic [ADDR_W-1:0] addr_q;
   logic [IDX_W-1:0]  byte_idx;
   logic [BUS_W-1:0]  cur_byte;
   logic              drive;

   rom_strap_decode #(
      .BUS_W(BUS_W), .ADDR_W(ADDR_W), .MASK_W(MASK_W),
      .MIN_LOG2(MIN_LOG2), .STRAP_DELAY(STRAP_DELAY), .NB_W(NB_W)
   ) i_strap (
      .clk(clk), .rst_n(rst_n), .bus_in(bus_in),
      .cfg_done(cfg_done), .present(present), .slow(slow),
      .nbytes(nbytes), .addr_mask(addr_mask), .base_mask(base_mask)
   );

   rom_cycle_fsm #(
      .ADDR_W(ADDR_W), .BUS_W(BUS_W), .NLATCH(NLATCH), .IDX_W(IDX_W),
      .NB_W(NB_W), .FAST_WAIT(FAST_WAIT), .SLOW_WAIT(SLOW_WAIT)
   ) i_fsm (
      .clk(clk), .rst_n(rst_n), .cfg_done(cfg_done), .present(present),
      .slow(slow), .nbytes(nbytes), .req(req), .addr_m(addr & addr_mask),
      .bus_in(bus_in), .addr_q(addr_q), .byte_idx(byte_idx), .drive(drive),
      .stb(latch_stb), .ce_n(ce_n), .oe_n(oe_n), .done(done), .rdata(rdata)
   );

   rom_addr_mux #(
      .ADDR_W(ADDR_W), .BUS_W(BUS_W), .NLATCH(NLATCH), .IDX_W(IDX_W)
   ) i_mux (
      .addr(addr_q), .sel(byte_idx), .byte_o(cur_byte)
   );

   assign bus_oe  = drive;
   assign bus_out = drive ? cur_byte : '0;

endmodule

// File: rtl/rom_bridge_chk.sv
module rom_bridge_chk #(
   parameter int BUS_W  = 8,
   parameter int NLATCH = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_done,
   input logic              bus_oe,
   input logic [BUS_W-1:0]  bus_out,
   input logic [NLATCH-1:0] latch_stb,
   input logic              ce_n,
   input logic              oe_n,
   input logic              done
);
   // R3
   stb_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(latch_stb));

   // R3
   stb_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|latch_stb) |-> ($past(bus_oe) && $stable(bus_out)));

   // R3
   stb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|latch_stb) |=> (bus_oe && $stable(bus_out) && (latch_stb == '0)));

   // R6
   no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_oe && (!ce_n || !oe_n)));

   // R6
   enable_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ce_n == oe_n);

   // R7
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R1
   strap_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_done |-> (!bus_oe && ce_n && !done && (latch_stb == '0)));

endmodule

bind exp_rom_bridge rom_bridge_chk #(.BUS_W(BUS_W), .NLATCH(NLATCH)) i_chk (
   .clk(clk), .rst_n(rst_n), .cfg_done(cfg_done), .bus_oe(bus_oe),
   .bus_out(bus_out), .latch_stb(latch_stb), .ce_n(ce_n), .oe_n(oe_n),
   .done(done)
);

// File: tb/test_exp_rom_bridge.sv
`timescale 1ns/1ps
module test_exp_rom_bridge;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req = 1'b0;
   logic [19:0] addr = '0;
   logic [7:0]  rdata;
   logic        done;
   logic [7:0]  bus_in;
   logic [7:0]  bus_out;
   logic        bus_oe;
   logic [2:0]  latch_stb;
   logic        ce_n;
   logic        oe_n;
   logic [31:0] base_mask;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 0;

   logic [7:0]  strap_drv = 8'h00;
   logic [7:0]  lat0 = '0, lat1 = '0, lat2 = '0;
   logic [23:0] amask_tb = '0;

   always #10 clk = ~clk;

   exp_rom_bridge i_exp_rom_bridge (
      .clk(clk), .rst_n(rst_n), .req(req), .addr(addr), .rdata(rdata),
      .done(done), .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
      .latch_stb(latch_stb), .ce_n(ce_n), .oe_n(oe_n), .base_mask(base_mask)
   );

   function automatic logic [7:0] rom_fn(input logic [23:0] a);
      return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h5A;
   endfunction

   always @(posedge latch_stb[0]) lat0 = bus_out;
   always @(posedge latch_stb[1]) lat1 = bus_out;
   always @(posedge latch_stb[2]) lat2 = bus_out;

   always_comb begin
      if (!ce_n && !oe_n) bus_in = rom_fn({lat2, lat1, lat0} & amask_tb);
      else                bus_in = strap_drv;
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [15:0] pins();
      return {bus_oe, bus_out, latch_stb, ce_n, oe_n, done, 1'b0};
   endfunction

   function automatic logic [15:0] mkpins(input bit oe, input logic [7:0] b,
                                          input logic [2:0] s, input bit ce,
                                          input bit d);
      return {oe, b, s, ce, ce, d, 1'b0};
   endfunction

   // reset, strap window and pre-configuration request
   task automatic do_reset(input logic [2:0] code, input bit slow);
      logic [7:0]  s;
      logic [31:0] emask;
      s = {4'hF, slow, code};
      emask = (code == 3'd7) ? 32'h0 : ~((32'h1 << (14 + code)) - 1);
      rst_n = 1'b0; req = 1'b0; strap_drv = ~s;
      repeat (3) @(negedge clk);
      // R10
      chk(pins() == mkpins(0, 8'h00, 3'b000, 1, 0) && rdata == 8'h00 &&
          base_mask == 32'h0, "R10 reset outputs", {16'h0, pins()}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      req = 1'b1; addr = 20'h12345;
      @(negedge clk);
      req = 1'b0;
      @(negedge clk);
      strap_drv = s;
      // R1
      chk(bus_oe == 1'b0 && base_mask == 32'h0, "R1 no drive, no config yet",
          {bus_oe, base_mask[30:0]}, 32'h0);
      @(negedge clk);
      strap_drv = ~s;
      // R2
      chk(base_mask == emask, "R2 base mask from straps", base_mask, emask);
      // R9
      for (int k = 0; k < 6; k++) begin
         chk(pins() == mkpins(0, 8'h00, 3'b000, 1, 0), "R9 pre-config request dropped",
             {16'h0, pins()}, {16'h0, mkpins(0, 8'h00, 3'b000, 1, 0)});
         @(negedge clk);
      end
   endtask

   task automatic run_txn(input logic [2:0] code, input bit slow,
                          input logic [19:0] a, input bit inject);
      int          lg, nb, w;
      logic [23:0] ma;
      logic [7:0]  exp_d;
      logic [7:0]  b;
      logic [2:0]  s;
      lg = 14 + code;
      nb = (lg + 7) / 8;
      w  = slow ? 7 : 3;
      amask_tb = (code == 3'd7) ? 24'h0 : ((24'h1 << lg) - 1);
      ma = {4'h0, a} & amask_tb;
      exp_d = rom_fn(ma);
      lat0 = '0; lat1 = '0; lat2 = '0;
      @(negedge clk);
      req = 1'b1; addr = a;
      @(negedge clk);
      req = 1'b0;
      if (code == 3'd7) begin
         // R8
         chk(pins() == mkpins(0, 8'h00, 3'b000, 1, 1) && rdata == 8'hFF,
             "R8 no-ROM immediate completion", {8'h0, rdata, pins()},
             {8'h0, 8'hFF, mkpins(0, 8'h00, 3'b000, 1, 1)});
         @(negedge clk);
         chk(done == 1'b0 && ce_n && rdata == 8'hFF, "R8 single pulse, data held",
             {done, ce_n, rdata}, {2'b01, 8'hFF});
         return;
      end
      for (int k = 0; k < 3 * nb + w; k++) begin
         if (k < 3 * nb) begin
            b = 8'(ma >> (8 * (k / 3)));
            s = ((k % 3) == 1) ? 3'(1 << (k / 3)) : 3'b000;
            // R3 R4 R5
            chk(pins() == mkpins(1, b, s, 1, 0), "R3 R4 R5 address byte cycle",
                {16'h0, pins()}, {16'h0, mkpins(1, b, s, 1, 0)});
         end else begin
            // R6
            chk(pins() == mkpins(0, 8'h00, 3'b000, 0, 0), "R6 enable window",
                {16'h0, pins()}, {16'h0, mkpins(0, 8'h00, 3'b000, 0, 0)});
         end
         if (inject && k == 1) begin req = 1'b1; addr = ~a; end
         if (inject && k == 2) req = 1'b0;
         @(negedge clk);
      end
      // R7
      chk(pins() == mkpins(0, 8'h00, 3'b000, 1, 1) && rdata == exp_d,
          "R7 done with captured byte", {8'h0, rdata, pins()},
          {8'h0, exp_d, mkpins(0, 8'h00, 3'b000, 1, 1)});
      @(negedge clk);
      // R7 R9
      chk(done == 1'b0 && ce_n && latch_stb == 3'b000 && rdata == exp_d,
          "R7 R9 pulse ends, data held, no extra read", {done, ce_n, latch_stb, rdata},
          {1'b0, 1'b1, 3'b000, exp_d});
      @(negedge clk);
      chk(done == 1'b0 && bus_oe == 1'b0 && rdata == exp_d, "R9 idle after read",
          {done, bus_oe, rdata}, {2'b00, exp_d});
   endtask

   initial begin
      logic [19:0] addrs [4];
      addrs[0] = 20'h00000; addrs[1] = 20'hFFFFF;
      addrs[2] = 20'hA5C3E; addrs[3] = 20'h1357B;
      for (int c = 0; c < 8; c++) begin
         for (int sp = 0; sp < 2; sp++) begin
            do_reset(3'(c), sp[0]);
            for (int i = 0; i < 4; i++) run_txn(3'(c), sp[0], addrs[i], i == 0);
            run_txn(3'(c), sp[0], 20'((c + 1) * 20'h1F0F1), 1'b0);
         end
      end
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(200000 * 20);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule